// File: doc/BRIEF.md
# Modem Controller Serial Control and Status Port

This block is the serial port of a telephony modem controller. Four wires reach it from the host side: a serial clock, a read/write select, a strobe, and one data line. The data line is split here into an input, an output and an output enable. In write mode the host clocks a 16-bit control word into a shadow shift register, one bit per serial clock edge. A later strobe copies the word into the active settings: function mode, transmit tone, carrier detect time, channel select, transmit squelch and transmit attenuator.

In read mode the strobe takes a snapshot of the 4-bit received-tone code from the tone decoder and puts its bit 0 on the data line. Each serial clock edge after that moves to the next bit. After bit 3 the output returns to bit 0, so the host can clock as many bits as it wants.

All pins are sampled by the system clock, and rising edges are found by comparing each sample with the one before. The port only captures, holds and presents the fields. It does not decode them.

Top module: `mdm_ser_port`

## Requirements
- R1: While `rst` is high at a clock edge, every active control field, the shadow register and the read bit pointer clear to zero, and `sdo` and `sdo_oe` go low.
- R2: While `rw` is low, each rising edge of `sck` shifts `sdi` into the shadow register MSB first. The field layout, from bit 15 down to bit 0, is mode[3:0], tone[3:0], carrier-detect time[1:0], channel, squelch, attenuator[3:0].
- R3: The active control fields keep their values until `e` rises while `rw` is low. That rising edge loads the whole shadow word, and the new values are visible one clock later.
- R4: When more than 16 bits are shifted before the strobe, only the 16 most recent bits are applied.
- R5: A rising edge of `e` while `rw` is high captures `dec_code` and drives its bit 0 on `sdo`.
- R6: During a read, each rising edge of `sck` moves `sdo` to the next captured bit, in the order 1, 2, 3, then back to 0, without end.
- R7: A change on `dec_code` after the read strobe has no effect on `sdo` until the next read strobe.
- R8: `sdo_oe` follows `rw`, one clock later.
- R9: Serial clock edges and strobes during a read leave both the shadow register and the active control fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial bit clock from the host |
| rw | input | 1 | Direction select: 0 = write control word, 1 = read status |
| e | input | 1 | Strobe: applies the control word (write) or starts a status read (read) |
| sdi | input | 1 | Input side of the data line |
| dec_code | input | 4 | Received-tone code from the tone decoder |
| sdo | output | 1 | Output side of the data line |
| sdo_oe | output | 1 | Output enable for the data line |
| mode | output | 4 | Active function mode |
| tone | output | 4 | Active transmit tone select |
| cdt | output | 2 | Active carrier detect time select |
| chan | output | 1 | Active channel select |
| sqlch | output | 1 | Active transmit squelch |
| atten | output | 4 | Active transmit attenuator setting |

## Verification
A shadow register that is off by one bit shows up on the active fields in the clock after the strobe, as the word shifted by one position. Because all the fields move together, a single written word makes a fault in the field layout visible. A read pointer that fails to wrap, or that moves without a serial clock edge, shows up on `sdo` at the fifth bit of a read or at the first idle cycle. A snapshot that tracks the decoder instead of holding the captured code shows up on the first `sck` edge after `dec_code` changes.

// File: rtl/mdm_ser_pkg.sv
package mdm_ser_pkg;
  localparam int MODE_W = 4;
  localparam int TONE_W = 4;
  localparam int CDT_W  = 2;
  localparam int ATT_W  = 4;
  localparam int CTRL_W = MODE_W + TONE_W + CDT_W + 1 + 1 + ATT_W;

  // Field order matches the serial bit order: first bit in lands in mode[MSB].
  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [TONE_W-1:0] tone;
    logic [CDT_W-1:0]  cdt;
    logic              chan;
    logic              sqlch;
    logic [ATT_W-1:0]  atten;
  } ctrl_word_t;
endpackage

// File: rtl/mdm_ser_edge.sv
module mdm_ser_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise[i] = pin[i] & ~prev_q[i];
  end
endmodule

// File: rtl/mdm_ser_ctrl.sv
module mdm_ser_ctrl
  import mdm_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       shift_stb,
  input  logic       latch_stb,
  input  logic       sdi,
  output ctrl_word_t ctrl_q
);
  logic [CTRL_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (shift_stb) begin
      shadow_q <= {shadow_q[CTRL_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ctrl_q <= '0;
    else if (latch_stb) ctrl_q <= ctrl_word_t'(shadow_q);
  end

  // R2: the newest bit sits at the bottom of the shadow register
  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    shift_stb |=> shadow_q[0] == $past(sdi));

  // R3: the active fields hold until a write-mode strobe
  p_hold_active_r3: assert property (@(posedge clk) disable iff (rst)
    !latch_stb |=> $stable(ctrl_q));

  // R3: a strobe applies the whole shadow word
  p_apply_word_r3: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> ctrl_q == ctrl_word_t'($past(shadow_q)));

  // R9: the shadow register moves only on a write-mode serial clock edge
  p_shadow_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !shift_stb |=> $stable(shadow_q));
endmodule

// File: rtl/mdm_ser_stat.sv
module mdm_ser_stat #(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_stb,
  input  logic              adv_stb,
  input  logic [STAT_W-1:0] code,
  output logic              sdo
);
  localparam int PTR_W = (STAT_W > 1) ? $clog2(STAT_W) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(STAT_W - 1);

  logic [STAT_W-1:0] snap_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_nx;

  assign ptr_nx = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      ptr_q  <= '0;
      sdo    <= 1'b0;
    end else if (load_stb) begin
      snap_q <= code;
      ptr_q  <= '0;
      sdo    <= code[0];
    end else if (adv_stb) begin
      ptr_q  <= ptr_nx;
      sdo    <= snap_q[ptr_nx];
    end
  end

  // R5: a read strobe presents bit 0 of the code at that edge
  p_first_bit_r5: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> sdo == $past(code[0]));

  // R6: after the last bit the pointer returns to bit 0
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (adv_stb && !load_stb && ptr_q == LAST) |=> ptr_q == '0);

  // R7: between strobes the snapshot and the output bit stay put
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> $stable(snap_q));
  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !adv_stb) |=> $stable(sdo));
endmodule

// File: rtl/mdm_ser_port.sv
module mdm_ser_port
  import mdm_ser_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              rw,
  input  logic              e,
  input  logic              sdi,
  input  logic [STAT_W-1:0] dec_code,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [MODE_W-1:0] mode,
  output logic [TONE_W-1:0] tone,
  output logic [CDT_W-1:0]  cdt,
  output logic              chan,
  output logic              sqlch,
  output logic [ATT_W-1:0]  atten
);
  logic [1:0] rise;
  logic       sck_rise;
  logic       e_rise;
  ctrl_word_t ctrl;

  mdm_ser_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .pin  ({e, sck}),
    .rise (rise)
  );
  assign sck_rise = rise[0];
  assign e_rise   = rise[1];

  mdm_ser_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .shift_stb (sck_rise & ~rw),
    .latch_stb (e_rise & ~rw),
    .sdi       (sdi),
    .ctrl_q    (ctrl)
  );

  mdm_ser_stat #(.STAT_W(STAT_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .load_stb (e_rise & rw),
    .adv_stb  (sck_rise & rw),
    .code     (dec_code),
    .sdo      (sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) sdo_oe <= 1'b0;
    else     sdo_oe <= rw;
  end

  assign mode  = ctrl.mode;
  assign tone  = ctrl.tone;
  assign cdt   = ctrl.cdt;
  assign chan  = ctrl.chan;
  assign sqlch = ctrl.sqlch;
  assign atten = ctrl.atten;

  // R8: the data line is driven only after a read-mode clock
  p_oe_follows_r8: assert property (@(posedge clk) disable iff (rst)
    rw |=> sdo_oe);
  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    !rw |=> !sdo_oe);

  // R9: activity during a read never touches the active fields
  p_read_no_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
    rw |=> $stable({mode, tone, cdt, chan, sqlch, atten}));
endmodule

// File: tb/mdm_ser_port_tb_top.sv
module mdm_ser_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       rw  = 1'b0;
  logic       e   = 1'b0;
  logic       sdi = 1'b0;
  logic [3:0] dec_code = 4'h0;
  logic       sdo, sdo_oe, chan, sqlch;
  logic [3:0] mode, tone, atten;
  logic [1:0] cdt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mdm_ser_port dut_i (
    .clk(clk), .rst(rst), .sck(sck), .rw(rw), .e(e), .sdi(sdi),
    .dec_code(dec_code), .sdo(sdo), .sdo_oe(sdo_oe),
    .mode(mode), .tone(tone), .cdt(cdt), .chan(chan), .sqlch(sqlch), .atten(atten)
  );

  localparam logic [15:0] WVEC [0:5] = '{16'hA5C3, 16'hFFFF, 16'h1234, 16'h8001, 16'h5A96, 16'h0000};
  localparam logic [3:0]  RVEC [0:3] = '{4'h6, 4'hB, 4'h1, 4'hE};

  function automatic logic [15:0] act_word();
    return {mode, tone, cdt, chan, sqlch, atten};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_sck(input logic d);
    sdi = d; sck = 1'b1; tick();
    sck = 1'b0; tick();
  endtask

  task automatic pulse_e();
    e = 1'b1; tick();
    e = 1'b0; tick();
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) pulse_sck(w[i]);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    tick(); tick(); tick();
    rst = 1'b0; tick();
    // R1 reset state
    check("R1 fields", act_word(), 16'h0000);
    check("R1 sdo", sdo, 1'b0);
    check("R1 sdo_oe", sdo_oe, 1'b0);

    // R2/R3 vector walk
    prev = 16'h0000;
    for (int k = 0; k < 6; k++) begin
      shift_word(WVEC[k]);
      check("R3 hold before strobe", act_word(), prev);
      pulse_e();
      check("R2 applied word", act_word(), WVEC[k]);
      prev = WVEC[k];
    end
    // R2 field layout on one word
    shift_word(16'b1001_0110_10_1_0_0011);
    pulse_e();
    check("R2 mode",  mode,  4'h9);
    check("R2 tone",  tone,  4'h6);
    check("R2 cdt",   cdt,   2'b10);
    check("R2 chan",  chan,  1'b1);
    check("R2 sqlch", sqlch, 1'b0);
    check("R2 atten", atten, 4'h3);

    // R4 overlong write keeps the last 16 bits
    for (int i = 0; i < 4; i++) pulse_sck(1'b1);
    shift_word(16'h0F0F);
    pulse_e();
    check("R4 last sixteen", act_word(), 16'h0F0F);

    // R8 output enable
    check("R8 oe low in write", sdo_oe, 1'b0);
    rw = 1'b1; tick();
    check("R8 oe high in read", sdo_oe, 1'b1);

    // R5/R6 reads with wrap
    for (int k = 0; k < 4; k++) begin
      dec_code = RVEC[k];
      tick();
      pulse_e();
      check("R5 first bit", sdo, RVEC[k][0]);
      for (int b = 1; b < 10; b++) begin
        pulse_sck(~sdi);
        check("R6 circular bit", sdo, RVEC[k][b % 4]);
      end
    end

    // R7 decoder change mid-read is ignored
    dec_code = 4'h6; tick();
    pulse_e();
    dec_code = 4'h9;
    for (int b = 1; b < 5; b++) begin
      pulse_sck(1'b1);
      check("R7 snapshot held", sdo, 32'((4'h6 >> (b % 4)) & 4'h1));
    end
    pulse_e();
    check("R7 new strobe takes new code", sdo, 1'b1);
    pulse_sck(1'b0);
    check("R7 new code bit1", sdo, 1'b0);

    // R9 read activity leaves the control path alone
    check("R9 active fields during read", act_word(), 16'h0F0F);
    rw = 1'b0; tick();
    check("R8 oe low again", sdo_oe, 1'b0);
    pulse_e();
    check("R9 shadow untouched by read", act_word(), 16'h0F0F);

    // R1 reset after activity
    shift_word(16'hBEEF);
    rw = 1'b1; tick(); pulse_e();
    rst = 1'b1; tick();
    rst = 1'b0; rw = 1'b0; tick();
    check("R1 fields after reset", act_word(), 16'h0000);
    check("R1 sdo after reset", sdo, 1'b0);
    pulse_e();
    check("R1 shadow cleared", act_word(), 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule